// File: doc/BRIEF.md
# Double-Buffered Serial DAC Waveform Player

This block drives a 16-bit serial DAC with a stream of samples at a programmable rate. A divider on the system clock issues one conversion strobe per sample. On each strobe the block picks one sample from the selected source and sends it as one serial frame. The frame is sent MSB first, with an active-low chip select held low for the whole frame, a serial clock and a data line.

There are three sample sources. The first is a pair of equal host waveform buffers. The host writes two periods of its waveform into the buffer that is not playing. The player replays the other buffer cyclically over addresses 0 to a programmed last address. A swap request from the host is held until the read address wraps, and only then do the buffers trade roles, so a waveform is never cut mid-period. The second source is a separate buffer that the device under test fills, so its writes never collide with host writes. The third is a bypass word taken straight from the device under test, for when buffer latency matters. A reserved select code mutes the output to zero.

Top module: `wavePlayerTop`

## Requirements
- R1: With `divLimit` held constant since reset, chip select falls once every `divLimit`+1 clock cycles. `divLimit` must be at least 32.
- R2: Each frame keeps `dacCsN` low for exactly 32 clock cycles and gives 16 serial clock pulses, each one cycle high. Data is sent MSB first. `dacSdi` does not change on a cycle where `dacSclk` rises, and `dacSclk` is only high while chip select is low.
- R3: With source code 0 (host), a frame carries the word stored at the current read address of the playing host buffer. The read address steps 0,1,…,`waveLen` and then returns to 0.
- R4: Host writes always go to the buffer that is not playing (`playBank` inverted). Words in the playing buffer do not change while it plays.
- R5: A `swapReq` pulse is remembered until the strobe that reads address `waveLen`. At that strobe `playBank` toggles and the pending request clears. `playBank` changes only on the cycle chip select falls.
- R6: With source code 1 (device stream), a frame carries the stream buffer word at a separate read pointer. This pointer advances on every strobe and wraps over the full buffer depth. Device writes may target any address at any time, and a read and write to the same address on the same edge returns the old word.
- R7: With source code 2 (bypass), a frame carries the value of `bypassData` at the clock edge where the strobe fires.
- R8: Source code 3 sends a frame of all zeros.
- R9: `srcSel` is sampled only at a strobe. A change during a frame affects the next frame, not the current one.
- R10: During reset `dacCsN` is 1, `dacSclk` and `dacSdi` are 0, `playBank` is 0, and both read pointers and the divider restart from zero.
- R11: The host read address and the stream pointer advance on every strobe, whatever source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divLimit | input | DIV_W | Strobe period minus one, in clock cycles |
| waveLen | input | ADDR_W | Last host buffer address replayed before wrapping |
| srcSel | input | 2 | Sample source: 0 host, 1 device stream, 2 bypass, 3 mute |
| swapReq | input | 1 | Host request to exchange the buffers at the next wrap |
| hostWrEn | input | 1 | Host write strobe into the idle host buffer |
| hostWrAddr | input | ADDR_W | Host write address |
| hostWrData | input | DATA_W | Host write word |
| devWrEn | input | 1 | Device-under-test write strobe into the stream buffer |
| devWrAddr | input | ADDR_W | Stream buffer write address |
| devWrData | input | DATA_W | Stream buffer write word |
| bypassData | input | DATA_W | Direct sample from the device under test |
| playBank | output | 1 | Index of the host buffer currently being played |
| dacCsN | output | 1 | Serial DAC chip select, active low |
| dacSclk | output | 1 | Serial DAC bit clock |
| dacSdi | output | 1 | Serial DAC data, MSB first |

## Verification
The strobe edge is the reference point. Chip select falls and `playBank` updates on that edge. Bit k is on `dacSdi` from 2k to 2k+2 cycles after it, with its serial clock high in the second of those cycles. Chip select rises 32 cycles after the strobe. The bench samples every output on the falling clock edge. It shifts in `dacSdi` only in cycles where `dacSclk` is high, checks `playBank` in the cycle chip select falls, and compares the whole 16-bit word with the value its reference model computed for that strobe in the cycle chip select rises. Each frame is therefore judged after all its registers have settled and before the next frame starts.

// File: rtl/wavePlayerPkg.sv
package wavePlayerPkg;

  typedef enum logic [1:0] {
    SRC_HOST   = 2'd0,
    SRC_DEV    = 2'd1,
    SRC_BYPASS = 2'd2,
    SRC_MUTE   = 2'd3
  } srcKind_e;

  // Strobes passed from control to datapath once per sample
  typedef struct packed {
    logic     load;   // conversion strobe: capture a sample, start a frame
    srcKind_e src;    // source latched for this sample
    logic     bank;   // host buffer being played
  } sampleCmd_t;

endpackage

// File: rtl/wavePlayerCtrl.sv
module wavePlayerCtrl
  import wavePlayerPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divLimit,
  input  logic [ADDR_W-1:0] waveLen,
  input  logic [1:0]        srcSel,
  input  logic              swapReq,
  output sampleCmd_t        cmd,
  output logic [ADDR_W-1:0] hostRdAddr,
  output logic [ADDR_W-1:0] devRdAddr,
  output logic              playBank
);

  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] hostPtr;
  logic [ADDR_W-1:0] devPtr;
  logic              bankSel;
  logic              swapPend;

  logic strobe;
  logic atWrap;
  logic pendNext;
  logic doSwap;

  always_comb begin
    strobe   = (divCnt == divLimit);
    atWrap   = (hostPtr >= waveLen);
    pendNext = swapPend | swapReq;
    doSwap   = strobe & atWrap & pendNext;
  end

  // Rate divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Read pointers: both move on every strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostPtr <= '0;
      devPtr  <= '0;
    end else if (strobe) begin
      hostPtr <= atWrap ? '0 : hostPtr + ADDR_W'(1);
      devPtr  <= devPtr + ADDR_W'(1);
    end
  end

  // Ping-pong bank and deferred swap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel  <= 1'b0;
      swapPend <= 1'b0;
    end else if (doSwap) begin
      bankSel  <= ~bankSel;
      swapPend <= 1'b0;
    end else begin
      swapPend <= pendNext;
    end
  end

  always_comb begin
    cmd.load   = strobe;
    cmd.src    = srcKind_e'(srcSel);
    cmd.bank   = bankSel;
    hostRdAddr = hostPtr;
    devRdAddr  = devPtr;
    playBank   = bankSel;
  end

endmodule

// File: rtl/wavePlayerPath.sv
module wavePlayerPath
  import wavePlayerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  sampleCmd_t        cmd,
  input  logic [ADDR_W-1:0] hostRdAddr,
  input  logic [ADDR_W-1:0] devRdAddr,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              devWrEn,
  input  logic [ADDR_W-1:0] devWrAddr,
  input  logic [DATA_W-1:0] devWrData,
  input  logic [DATA_W-1:0] bypassData,
  output logic              dacCsN,
  output logic              dacSclk,
  output logic              dacSdi
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NBANK   = 2;
  localparam int BCNT_W  = $clog2(DATA_W);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] bankRd [NBANK];
  logic [DATA_W-1:0] devRd;
  logic              wrBank;

  assign wrBank = ~cmd.bank;

  // Host ping-pong buffers
  for (genvar g = 0; g < NBANK; g++) begin : gBank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (hostWrEn && (wrBank == 1'(g))) begin
        mem[hostWrAddr] <= hostWrData;
      end
    end
    assign bankRd[g] = mem[hostRdAddr];
  end

  // Device stream buffer
  logic [DATA_W-1:0] devMem [DEPTH];
  always_ff @(posedge clk) begin
    if (devWrEn) begin
      devMem[devWrAddr] <= devWrData;
    end
  end
  assign devRd = devMem[devRdAddr];

  // Source mux
  logic [DATA_W-1:0] sample;
  always_comb begin
    case (cmd.src)
      SRC_HOST:   sample = bankRd[cmd.bank];
      SRC_DEV:    sample = devRd;
      SRC_BYPASS: sample = bypassData;
      default:    sample = '0;
    endcase
  end

  // Serializer: two clocks per bit, low then high
  logic              busy;
  logic              phase;
  logic [BCNT_W-1:0] bitCnt;
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      bitCnt <= '0;
      shReg  <= '0;
    end else if (cmd.load) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      bitCnt <= '0;
      shReg  <= sample;
    end else if (busy) begin
      if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        shReg <= shReg << 1;
        if (bitCnt == LAST_BIT) begin
          busy <= 1'b0;
        end else begin
          bitCnt <= bitCnt + BCNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    dacCsN  = ~busy;
    dacSclk = busy & phase;
    dacSdi  = busy & shReg[DATA_W-1];
  end

endmodule

// File: rtl/wavePlayerTop.sv
module wavePlayerTop
  import wavePlayerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divLimit,
  input  logic [ADDR_W-1:0] waveLen,
  input  logic [1:0]        srcSel,
  input  logic              swapReq,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              devWrEn,
  input  logic [ADDR_W-1:0] devWrAddr,
  input  logic [DATA_W-1:0] devWrData,
  input  logic [DATA_W-1:0] bypassData,
  output logic              playBank,
  output logic              dacCsN,
  output logic              dacSclk,
  output logic              dacSdi
);

  sampleCmd_t        cmd;
  logic [ADDR_W-1:0] hostRdAddr;
  logic [ADDR_W-1:0] devRdAddr;

  wavePlayerCtrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .divLimit   (divLimit),
    .waveLen    (waveLen),
    .srcSel     (srcSel),
    .swapReq    (swapReq),
    .cmd        (cmd),
    .hostRdAddr (hostRdAddr),
    .devRdAddr  (devRdAddr),
    .playBank   (playBank)
  );

  wavePlayerPath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .hostRdAddr (hostRdAddr),
    .devRdAddr  (devRdAddr),
    .hostWrEn   (hostWrEn),
    .hostWrAddr (hostWrAddr),
    .hostWrData (hostWrData),
    .devWrEn    (devWrEn),
    .devWrAddr  (devWrAddr),
    .devWrData  (devWrData),
    .bypassData (bypassData),
    .dacCsN     (dacCsN),
    .dacSclk    (dacSclk),
    .dacSdi     (dacSdi)
  );

endmodule

// File: rtl/wavePlayerChk.sv
module wavePlayerChk #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] divLimit,
  input logic             playBank,
  input logic             dacCsN,
  input logic             dacSclk,
  input logic             dacSdi
);

  localparam int FRAME_CYC = 2 * DATA_W;
  localparam int LOW_W     = $clog2(FRAME_CYC) + 2;
  localparam int GAP_W     = DIV_W + 1;

  logic [LOW_W-1:0] lowCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             seenFall;
  logic             csPrev;
  logic             csFell;

  assign csFell = csPrev & ~dacCsN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      gapCnt   <= '0;
      seenFall <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      csPrev <= dacCsN;
      lowCnt <= dacCsN ? '0 : lowCnt + LOW_W'(1);
      if (csFell) begin
        gapCnt   <= GAP_W'(1);
        seenFall <= 1'b1;
      end else begin
        gapCnt <= gapCnt + GAP_W'(1);
      end
    end
  end

  // R1: strobe spacing
  assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csFell && seenFall) |-> (gapCnt == GAP_W'(divLimit) + GAP_W'(1)));

  // R2: frame length
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacCsN) |-> (lowCnt == LOW_W'(FRAME_CYC)));

  // R2: serial clock confined to the frame
  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    dacSclk |-> !dacCsN);

  // R2: data settled before the rising serial clock
  assert_sdi_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacSclk) |-> $stable(dacSdi));

  // R5: bank changes only at a sample boundary
  assert_bank_at_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(playBank) |-> $fell(dacCsN));

endmodule

bind wavePlayerTop wavePlayerChk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .divLimit (divLimit),
  .playBank (playBank),
  .dacCsN   (dacCsN),
  .dacSclk  (dacSclk),
  .dacSdi   (dacSdi)
);

// File: tb/test_wavePlayerTop.sv
module test_wavePlayerTop;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int DIV_W      = 16;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk;
  logic              rstN;
  logic [DIV_W-1:0]  divLimit;
  logic [ADDR_W-1:0] waveLen;
  logic [1:0]        srcSel;
  logic              swapReq;
  logic              hostWrEn;
  logic [ADDR_W-1:0] hostWrAddr;
  logic [DATA_W-1:0] hostWrData;
  logic              devWrEn;
  logic [ADDR_W-1:0] devWrAddr;
  logic [DATA_W-1:0] devWrData;
  logic [DATA_W-1:0] bypassData;
  logic              playBank;
  logic              dacCsN;
  logic              dacSclk;
  logic              dacSdi;

  wavePlayerTop #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_wavePlayerTop (
    .clk(clk), .rstN(rstN), .divLimit(divLimit), .waveLen(waveLen),
    .srcSel(srcSel), .swapReq(swapReq),
    .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .devWrEn(devWrEn), .devWrAddr(devWrAddr), .devWrData(devWrData),
    .bypassData(bypassData), .playBank(playBank),
    .dacCsN(dacCsN), .dacSclk(dacSclk), .dacSdi(dacSdi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model (from the requirements) ----------------
  typedef struct {
    logic [DATA_W-1:0] val;
    bit                valid;
    int                src;
  } exp_t;

  exp_t              expQ[$];
  logic [DATA_W-1:0] mHost [2][DEPTH];
  bit                vHost [2][DEPTH];
  logic [DATA_W-1:0] mDev  [DEPTH];
  bit                vDev  [DEPTH];
  int                mCnt;
  int                mHostPtr;
  int                mDevPtr;
  bit                mBank;
  bit                mPend;

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) vHost[b][a] = 0;
    for (int a = 0; a < DEPTH; a++) vDev[a] = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mHostPtr = 0; mDevPtr = 0; mBank = 0; mPend = 0;
      expQ.delete();
    end else begin
      bit   oldBank;
      bit   pendNext;
      exp_t e;
      oldBank  = mBank;
      pendNext = mPend | swapReq;
      if (mCnt == int'(divLimit)) begin
        e.src = int'(srcSel);
        case (srcSel)
          2'd0: begin e.val = mHost[mBank][mHostPtr]; e.valid = vHost[mBank][mHostPtr]; end
          2'd1: begin e.val = mDev[mDevPtr]; e.valid = vDev[mDevPtr]; end
          2'd2: begin e.val = bypassData; e.valid = 1; end
          default: begin e.val = '0; e.valid = 1; end
        endcase
        expQ.push_back(e);
        if (mHostPtr >= int'(waveLen)) begin
          mHostPtr = 0;
          if (pendNext) begin mBank = ~mBank; mPend = 0; end
          else mPend = pendNext;
        end else begin
          mHostPtr++;
          mPend = pendNext;
        end
        mDevPtr = (mDevPtr + 1) % DEPTH;
        mCnt = 0;
      end else begin
        mCnt++;
        mPend = pendNext;
      end
      if (hostWrEn) begin
        mHost[~oldBank][hostWrAddr] = hostWrData;
        vHost[~oldBank][hostWrAddr] = 1;
      end
      if (devWrEn) begin
        mDev[devWrAddr] = devWrData;
        vDev[devWrAddr] = 1;
      end
    end
  end

  // ---------------- serial receiver, sampled on the falling edge ----------------
  int                cyc;
  int                lastFall;
  bit                haveFall;
  bit                prevCs;
  int                lowCnt;
  int                nBits;
  logic [DATA_W-1:0] rxWord;

  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; haveFall = 0; prevCs = 1; lowCnt = 0; nBits = 0; rxWord = '0;
    end else if (!done) begin
      cyc++;
      if (!dacCsN && prevCs) begin
        if (haveFall)
          chk((cyc - lastFall) == int'(divLimit) + 1, "R1 strobe period",
              32'(cyc - lastFall), 32'(int'(divLimit) + 1));
        haveFall = 1; lastFall = cyc;
        lowCnt = 0; nBits = 0; rxWord = '0;
        chk(playBank == mBank, "R5 playBank at boundary", 32'(playBank), 32'(mBank));
      end
      if (!dacCsN) begin
        lowCnt++;
        if (dacSclk) begin
          rxWord = {rxWord[DATA_W-2:0], dacSdi};
          nBits++;
        end
      end
      if (dacCsN && !prevCs) begin
        chk(lowCnt == 2*DATA_W, "R2 frame length", 32'(lowCnt), 32'(2*DATA_W));
        chk(nBits == DATA_W, "R2 bit count", 32'(nBits), 32'(DATA_W));
        if (expQ.size() == 0) begin
          chk(0, "R2 unexpected frame", 32'(rxWord), 32'(0));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (e.valid) begin
            case (e.src)
              0: chk(rxWord == e.val, "R3 R4 R9 R11 host word", 32'(rxWord), 32'(e.val));
              1: chk(rxWord == e.val, "R6 R9 R11 stream word", 32'(rxWord), 32'(e.val));
              2: chk(rxWord == e.val, "R7 R9 bypass word", 32'(rxWord), 32'(e.val));
              default: chk(rxWord == e.val, "R8 R9 mute word", 32'(rxWord), 32'(e.val));
            endcase
          end
        end
      end
      prevCs = dacCsN;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idleInputs();
    hostWrEn = 0; devWrEn = 0; swapReq = 0;
  endtask

  task automatic startSeg(input int dl, input int wl, input int src);
    @(negedge clk);
    rstN = 0;
    idleInputs();
    divLimit = DIV_W'(dl);
    waveLen  = ADDR_W'(wl);
    srcSel   = 2'(src);
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic runRand(input int cycles, input bit srcRand, input int swapOdds);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      hostWrEn   = ($urandom % 2) == 0;
      hostWrAddr = ADDR_W'($urandom);
      hostWrData = DATA_W'($urandom);
      devWrEn    = ($urandom % 3) == 0;
      devWrAddr  = ADDR_W'($urandom);
      devWrData  = DATA_W'($urandom);
      bypassData = DATA_W'($urandom);
      swapReq    = ($urandom % swapOdds) == 0;
      if (srcRand && ($urandom % 100) == 0) srcSel = 2'($urandom);
    end
    @(negedge clk);
    idleInputs();
  endtask

  task automatic fillHost();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      hostWrEn = 1; hostWrAddr = ADDR_W'(a); hostWrData = DATA_W'($urandom);
      devWrEn = 1; devWrAddr = ADDR_W'(a); devWrData = DATA_W'($urandom);
    end
    @(negedge clk);
    idleInputs();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 0;
    idleInputs();
    divLimit = DIV_W'(40); waveLen = ADDR_W'(15); srcSel = 2'd0;
    hostWrAddr = '0; hostWrData = '0; devWrAddr = '0; devWrData = '0; bypassData = '0;
    repeat (4) @(negedge clk);
    chk(dacCsN == 1'b1, "R10 reset csN", 32'(dacCsN), 32'(1));
    chk(dacSclk == 1'b0, "R10 reset sclk", 32'(dacSclk), 32'(0));
    chk(dacSdi == 1'b0, "R10 reset sdi", 32'(dacSdi), 32'(0));
    chk(playBank == 1'b0, "R10 reset playBank", 32'(playBank), 32'(0));

    // Fill idle bank and stream, swap in, fill the other bank
    rstN = 1;
    fillHost();
    @(negedge clk); swapReq = 1;
    @(negedge clk); swapReq = 0;
    for (int i = 0; i < 2000 && playBank == 1'b0; i++) @(negedge clk);
    chk(playBank == 1'b1, "R5 swap taken at wrap", 32'(playBank), 32'(1));
    fillHost();

    // Host playback with refills and swaps, then mixed sources
    runRand(12000, 0, 400);
    runRand(12000, 1, 200);

    // Corner: shortest period and single-sample waveform
    startSeg(32, 0, 0);
    runRand(8000, 0, 40);

    // Corner: full-depth waveform, long period
    startSeg(60, DEPTH-1, 0);
    runRand(12000, 1, 300);

    // Directed source sweep with mid-frame select changes
    startSeg(33, 7, 2);
    runRand(2000, 0, 100);
    for (int s = 0; s < 4; s++) begin
      @(negedge dacCsN);
      repeat (5) @(negedge clk);
      srcSel = 2'(s);
      runRand(2000, 0, 100);
    end

    repeat (100) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule